// File: doc/BRIEF.md
# Power-On Register Script Loader

This block brings a register space to its start-up configuration without help from software. After reset it walks a script held in a non-volatile memory, one 32-bit entry per word from word 0 upward. Each entry names a register and a value, and the block issues it as a single write on a simple register bus that has a ready handshake. An array register, such as a window lookup table, is filled by a run of entries that all name the same register. Each element is written in turn, in stored order.

The script ends at a terminator word or when a stored entry count is reached, whichever comes first. The block then raises a done flag and hands the register bus to the host. Until that point, host writes are held off. The script is replayed only after a reset, so editing the stored words has no effect on live registers until the next reset.

Top module: `cfg_replay_loader`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `load_done`, `reg_wr_en`, `nvm_rd_en` and `host_wr_ready` are all low.
- R2: Each entry holds the register number in bits 31:16 and the value in bits 15:0. Each entry that is not a terminator produces exactly one write on the register bus. The writes follow stored order, starting at word 0.
- R3: Consecutive entries that name the same register number produce the same number of consecutive writes to that register, each with its own value. Entries are never merged or skipped.
- R4: The word 0xFFFF_FFFF ends the script. It is not written, and no word stored after it is read or written.
- R5: When `script_count` entries have been issued, the script ends without reading word `script_count`.
- R6: Read addresses rise by one from 0, with one read strobe per entry. No new read is issued while a read is outstanding. Read data is taken exactly 2 cycles after its strobe.
- R7: A loader write stays asserted, with unchanged address and value, until the cycle in which `reg_wr_ready` is high.
- R8: Before `load_done`, `host_wr_ready` is low and no host write reaches the register bus. After `load_done`, the register bus carries the host's enable, address and value in the same cycle, and `host_wr_ready` follows `reg_wr_ready`.
- R9: An empty script, meaning either a terminator at word 0 or `script_count` equal to 0, raises `load_done` within 5 cycles of reset release and issues no write.
- R10: After `load_done`, the loader issues no further read and no write, even if the memory contents change. A later reset replays the current contents.
- R11: Once high, `load_done` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| script_count | input | ADDR_W+1 | Number of stored entries; the script ends when this many have been issued |
| nvm_rd_en | output | 1 | Read strobe to the script memory |
| nvm_rd_addr | output | ADDR_W | Word address of the read |
| nvm_rd_data | input | 32 | Read data, valid 2 cycles after the strobe |
| host_wr_en | input | 1 | Host write request |
| host_wr_addr | input | 16 | Host write register number |
| host_wr_data | input | 16 | Host write value |
| host_wr_ready | output | 1 | Host write accepted this cycle |
| reg_wr_en | output | 1 | Register bus write strobe |
| reg_wr_addr | output | 16 | Register bus register number |
| reg_wr_data | output | 16 | Register bus value |
| reg_wr_ready | input | 1 | Register bus accepts the write this cycle |
| load_done | output | 1 | Script fully applied; bus owned by host |

## Verification
Several properties are checked on every cycle:
- a stalled loader write holds steady;
- the done flag is sticky;
- a terminator ends the script without a write;
- at most one memory read is outstanding;
- no read is issued once loading is complete.

Other behaviours can only be shown by the bench's scenarios:
- the exact order and content of the replayed writes, including runs of the same register;
- the count limit and the empty-script timing;
- host blocking and hand-over;
- the fact that a changed memory takes effect only after a new reset.

The memory model in the bench presents valid data only in the exact cycle it is due. A loader that samples at the wrong time therefore writes a wrong value that the bench can see.

// File: rtl/cfg_replay_pkg.sv
// Shared definitions for the power-on register script loader.
// Assumes fixed 32-bit script entries: register number above, value below.
package cfg_replay_pkg;
    localparam int REG_W   = 16;
    localparam int VAL_W   = 16;
    localparam int ENTRY_W = REG_W + VAL_W;
    localparam logic [ENTRY_W-1:0] TERMINATOR = '1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_ISSUE,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [VAL_W-1:0] data;
    } reg_wr_t;
endpackage

// File: rtl/nvm_read_tracker.sv
// Tracks reads in flight to a memory with a fixed read latency.
// Raises rd_valid in the cycle that is RD_LAT cycles after a strobe.
// Assumes the memory returns one word per strobe, in order.
module nvm_read_tracker #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    output logic rd_valid
);
    logic [RD_LAT-1:0] pipe;

    generate
        if (RD_LAT == 1) begin : g_lat1
            // Single stage: valid one cycle after the strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= rd_en;
            end
        end else begin : g_latn
            // Shift the strobe through RD_LAT stages.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[RD_LAT-2:0], rd_en};
            end
        end
    endgenerate

    assign rd_valid = pipe[RD_LAT-1];

    // R6: a new strobe only when nothing is in flight.
    a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (pipe == '0));
endmodule

// File: rtl/script_sequencer.sv
// Walks the script memory from word 0.
// Each entry is turned into one register write; a terminator word or the
// entry count ends the script, after which done is held until reset.
// Assumes rd_valid marks the single cycle in which rd_data is the answer.
module script_sequencer
    import cfg_replay_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W:0]    script_count,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_valid,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic               wr_en,
    output logic [REG_W-1:0]   wr_addr,
    output logic [VAL_W-1:0]   wr_data,
    input  logic               wr_ready,
    output logic               done
);
    seq_state_t      state;
    logic [ADDR_W:0] idx;
    reg_wr_t         entry;
    logic            more;

    assign more = (idx < script_count);

    // State, entry index and held entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            entry <= '0;
        end else begin
            case (state)
                S_IDLE:  state <= S_FETCH;
                S_FETCH: state <= more ? S_WAIT : S_DONE;
                S_WAIT: begin
                    if (rd_valid) begin
                        if (rd_data == TERMINATOR) begin
                            state <= S_DONE;
                        end else begin
                            entry <= reg_wr_t'(rd_data);
                            state <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (wr_ready) begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                default: state <= S_DONE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rd_en   = (state == S_FETCH) && more;
        rd_addr = idx[ADDR_W-1:0];
        wr_en   = (state == S_ISSUE);
        wr_addr = entry.addr;
        wr_data = entry.data;
        done    = (state == S_DONE);
    end

    // R7: a stalled write is held unchanged.
    a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

    // R11: completion is sticky.
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R4: a terminator ends the script with no write.
    a_r4_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && rd_valid && rd_data == TERMINATOR) |=> (done && !wr_en));
endmodule

// File: rtl/reg_bus_mux.sv
// Gives the register bus to the loader until loading is complete, then to
// the host. The host sees no ready while the loader owns the bus.
// Assumes host_sel changes only at a clean boundary (loader idle).
module reg_bus_mux
    import cfg_replay_pkg::*;
(
    input  logic             host_sel,
    input  logic             ldr_en,
    input  logic [REG_W-1:0] ldr_addr,
    input  logic [VAL_W-1:0] ldr_data,
    output logic             ldr_ready,
    input  logic             host_en,
    input  logic [REG_W-1:0] host_addr,
    input  logic [VAL_W-1:0] host_data,
    output logic             host_ready,
    output logic             bus_en,
    output logic [REG_W-1:0] bus_addr,
    output logic [VAL_W-1:0] bus_data,
    input  logic             bus_ready
);
    // Select the bus owner and route ready back to it.
    always_comb begin
        if (host_sel) begin
            bus_en   = host_en;
            bus_addr = host_addr;
            bus_data = host_data;
        end else begin
            bus_en   = ldr_en;
            bus_addr = ldr_addr;
            bus_data = ldr_data;
        end
        host_ready = host_sel & bus_ready;
        ldr_ready  = ~host_sel & bus_ready;
    end
endmodule

// File: rtl/cfg_replay_loader.sv
// Top of the power-on register script loader.
// Replays a stored list of register writes after every reset, then hands
// the register bus to the host.
// Assumes a script memory with RD_LAT cycles of read latency.
module cfg_replay_loader
    import cfg_replay_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int RD_LAT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W:0]    script_count,
    output logic               nvm_rd_en,
    output logic [ADDR_W-1:0]  nvm_rd_addr,
    input  logic [ENTRY_W-1:0] nvm_rd_data,
    input  logic               host_wr_en,
    input  logic [REG_W-1:0]   host_wr_addr,
    input  logic [VAL_W-1:0]   host_wr_data,
    output logic               host_wr_ready,
    output logic               reg_wr_en,
    output logic [REG_W-1:0]   reg_wr_addr,
    output logic [VAL_W-1:0]   reg_wr_data,
    input  logic               reg_wr_ready,
    output logic               load_done
);
    logic             rd_valid;
    logic             ldr_en;
    logic [REG_W-1:0] ldr_addr;
    logic [VAL_W-1:0] ldr_data;
    logic             ldr_ready;

    nvm_read_tracker #(.RD_LAT(RD_LAT)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (nvm_rd_en),
        .rd_valid (rd_valid)
    );

    script_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .script_count (script_count),
        .rd_en        (nvm_rd_en),
        .rd_addr      (nvm_rd_addr),
        .rd_valid     (rd_valid),
        .rd_data      (nvm_rd_data),
        .wr_en        (ldr_en),
        .wr_addr      (ldr_addr),
        .wr_data      (ldr_data),
        .wr_ready     (ldr_ready),
        .done         (load_done)
    );

    reg_bus_mux u_mux (
        .host_sel   (load_done),
        .ldr_en     (ldr_en),
        .ldr_addr   (ldr_addr),
        .ldr_data   (ldr_data),
        .ldr_ready  (ldr_ready),
        .host_en    (host_wr_en),
        .host_addr  (host_wr_addr),
        .host_data  (host_wr_data),
        .host_ready (host_wr_ready),
        .bus_en     (reg_wr_en),
        .bus_addr   (reg_wr_addr),
        .bus_data   (reg_wr_data),
        .bus_ready  (reg_wr_ready)
    );

    // R10: no script reads once loading has finished.
    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !nvm_rd_en);
endmodule

// File: tb/tb_cfg_replay_loader.sv
module tb_cfg_replay_loader;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int TBL_N      = 12;
    localparam logic [31:0] SCRIPT_TBL [TBL_N] = '{
        32'h0014_0002, 32'h0017_0100, 32'h0018_302A, 32'h0019_0010,
        32'h0019_0020, 32'h0019_0030, 32'h0019_0040, 32'h0005_ABCD,
        32'h0019_0050, 32'hFFFF_FFFF, 32'h0042_DEAD, 32'h0043_BEEF
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W:0]   script_count = '0;
    logic              nvm_rd_en;
    logic [ADDR_W-1:0] nvm_rd_addr;
    logic [31:0]       nvm_rd_data;
    logic              host_wr_en = 1'b0;
    logic [15:0]       host_wr_addr = '0;
    logic [15:0]       host_wr_data = '0;
    logic              host_wr_ready;
    logic              reg_wr_en;
    logic [15:0]       reg_wr_addr;
    logic [15:0]       reg_wr_data;
    logic              reg_wr_ready;
    logic              load_done;

    cfg_replay_loader #(.ADDR_W(ADDR_W), .RD_LAT(2)) dut (
        .clk(clk), .rst_n(rst_n), .script_count(script_count),
        .nvm_rd_en(nvm_rd_en), .nvm_rd_addr(nvm_rd_addr), .nvm_rd_data(nvm_rd_data),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_wr_ready(host_wr_ready), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_wr_ready(reg_wr_ready), .load_done(load_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Script memory: data is valid only in the cycle 2 cycles after the strobe.
    logic [31:0] mem [DEPTH];
    logic [31:0] st1;
    logic [31:0] st2;
    logic        v1;
    always @(posedge clk) begin
        if (nvm_rd_en) st1 <= mem[nvm_rd_addr];
        v1  <= nvm_rd_en;
        st2 <= v1 ? st1 : 32'h0BAD_0BAD;
    end
    assign nvm_rd_data = st2;

    // Bus ready: always high or pseudo-random.
    logic       stall = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic       rdy_q = 1'b1;
    always @(posedge clk) begin
        lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy_q <= stall ? lfsr[0] : 1'b1;
    end
    assign reg_wr_ready = rdy_q;

    // Monitor, sampled mid-cycle.
    int          n_wr, n_rd, bad_rd, host_leak, post_rd, post_wr;
    logic [15:0] log_addr [DEPTH];
    logic [15:0] log_data [DEPTH];
    always @(negedge clk) begin
        if (rst_n && !load_done) begin
            if (reg_wr_en && reg_wr_ready) begin
                if (n_wr < DEPTH) begin
                    log_addr[n_wr] = reg_wr_addr;
                    log_data[n_wr] = reg_wr_data;
                end
                n_wr++;
            end
            if (nvm_rd_en) begin
                if (int'(nvm_rd_addr) != n_rd) bad_rd++;
                n_rd++;
            end
            if (host_wr_ready) host_leak++;
        end else if (rst_n && load_done) begin
            if (nvm_rd_en) post_rd++;
            if (reg_wr_en && !host_wr_en) post_wr++;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int done_cycles;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < DEPTH; i++)
            mem[i] = (i < TBL_N) ? SCRIPT_TBL[i] : (32'h0042_0000 + i);
    endtask

    // Reset, release, wait for completion; optional host pressure during load.
    task automatic run_load(input int cnt, input bit stl, input bit poke);
        rst_n = 1'b0;
        script_count = cnt[ADDR_W:0];
        stall = stl;
        repeat (3) @(posedge clk);
        n_wr = 0; n_rd = 0; bad_rd = 0; host_leak = 0; post_rd = 0; post_wr = 0;
        #1;
        rst_n = 1'b1;
        if (poke) begin
            host_wr_en = 1'b1; host_wr_addr = 16'h0BAD; host_wr_data = 16'hBAD0;
        end
        done_cycles = 0;
        while (!load_done && done_cycles < 3000) begin
            @(negedge clk);
            done_cycles++;
        end
        host_wr_en = 1'b0;
        if (!load_done) chk(1'b0, "R11 load timeout", 32'(done_cycles), 32'd3000);
    endtask

    int exp_n;
    string tag;

    initial begin
        fill_mem();
        // R1: reset state.
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!load_done && !reg_wr_en && !nvm_rd_en && !host_wr_ready, "R1 reset outputs",
            {28'd0, load_done, reg_wr_en, nvm_rd_en, host_wr_ready}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!load_done && !reg_wr_en && !nvm_rd_en && !host_wr_ready, "R1 first cycle",
            {28'd0, load_done, reg_wr_en, nvm_rd_en, host_wr_ready}, 32'd0);

        // Expected write count: entries before the terminator.
        exp_n = TBL_N;
        for (int i = TBL_N - 1; i >= 0; i--)
            if (SCRIPT_TBL[i] == 32'hFFFF_FFFF) exp_n = i;

        // Table walk, without and with bus stalls, with host pressure.
        for (int pass = 0; pass < 2; pass++) begin
            run_load(DEPTH, pass[0], 1'b1);
            chk(n_wr == exp_n, "R4 write count", 32'(n_wr), 32'(exp_n));
            chk(n_rd == exp_n + 1, "R6 read count", 32'(n_rd), 32'(exp_n + 1));
            chk(bad_rd == 0, "R6 read order", 32'(bad_rd), 32'd0);
            chk(host_leak == 0, "R8 host blocked", 32'(host_leak), 32'd0);
            for (int i = 0; i < exp_n; i++) begin
                tag = (pass == 1) ? "R7" :
                      ((i > 0 && SCRIPT_TBL[i][31:16] == SCRIPT_TBL[i-1][31:16]) ? "R3" : "R2");
                chk({log_addr[i], log_data[i]} == SCRIPT_TBL[i], tag,
                    {log_addr[i], log_data[i]}, SCRIPT_TBL[i]);
            end
        end

        // R8: host write passes after done.
        stall = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        host_wr_en = 1'b1; host_wr_addr = 16'h0030; host_wr_data = 16'h1234;
        @(negedge clk);
        chk(reg_wr_en && reg_wr_addr == 16'h0030 && reg_wr_data == 16'h1234, "R8 host pass",
            {reg_wr_addr, reg_wr_data}, 32'h0030_1234);
        chk(host_wr_ready == reg_wr_ready, "R8 host ready", 32'(host_wr_ready), 32'(reg_wr_ready));
        @(posedge clk); #1 host_wr_en = 1'b0;
        @(negedge clk);
        chk(!reg_wr_en, "R8 host idle", 32'(reg_wr_en), 32'd0);

        // R10 / R11: memory change after done has no effect until reset.
        mem[0] = 32'h0077_5555;
        repeat (20) @(negedge clk);
        chk(post_rd == 0 && post_wr == 0, "R10 quiet after done", 32'(post_rd + post_wr), 32'd0);
        chk(load_done, "R11 done held", 32'(load_done), 32'd1);
        run_load(DEPTH, 1'b0, 1'b0);
        chk({log_addr[0], log_data[0]} == 32'h0077_5555, "R10 replay after reset",
            {log_addr[0], log_data[0]}, 32'h0077_5555);
        fill_mem();

        // R5: count limit stops before the terminator.
        run_load(3, 1'b0, 1'b0);
        chk(n_wr == 3 && n_rd == 3, "R5 count limit", 32'(n_wr * 256 + n_rd), 32'h0000_0303);

        // R9: empty by count.
        run_load(0, 1'b0, 1'b0);
        chk(n_wr == 0 && done_cycles <= 5, "R9 count zero", 32'(done_cycles), 32'd5);

        // R9: empty by terminator at word 0.
        mem[0] = 32'hFFFF_FFFF;
        run_load(DEPTH, 1'b0, 1'b0);
        chk(n_wr == 0 && done_cycles <= 5, "R9 terminator first", 32'(n_wr * 256 + done_cycles), 32'd5);
        fill_mem();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule